// File: doc/BRIEF.md
# Elliptic-Curve Ladder Point-Multiplication Sequencer

This block is the control sequencer for a Montgomery-ladder point multiplication over a binary field. It sits in idle until a start pulse arrives. It then runs a short conversion of the base point into projective coordinates. Next comes the ladder body, once for each scalar bit below the most significant one. The run ends with two field inversions and a closing projective-to-affine sequence. In each state the block issues one micro-operation for a two-stage pipelined field datapath. The operation is a multiply, an add, a square or a bubble, and it comes with destination and operand register selects.

The scalar is captured when start is accepted, and the ladder scans it from bit KEY_W-2 down to bit 0. The state index and the scanned key bit are visible at the ports. A one-cycle done pulse marks the end of the run. The datapath, the register file and the field multiplier are outside this block.

Top module: `ecpm_sequencer`

## Requirements
- R1: After reset the state index is 0, done is 0 and the operation code is 0 (no operation). The code values are 0 none, 1 multiply, 2 add and 3 square.
- R2: In state 0 the machine stays in state 0 while start is low. When start is high in state 0, the state index is 1 one cycle later.
- R3: States 1 to 6 follow one another in order, and state 7 comes after state 6.
- R4: The ladder runs states 7 to 23 in order, once for each scalar bit index from KEY_W-2 down to 0. During each pass key_bit equals the captured scalar bit at that index. After the index-0 pass, state 24 follows state 23; after any other pass, state 7 follows it.
- R5: Every ladder pass issues exactly 6 multiplies, 3 adds, 5 squares and 3 bubbles.
- R6: In a ladder state the fields issued for key bit 0 are the fields for key bit 1 with register selects 1 and 3 exchanged and selects 2 and 4 exchanged. The code stays the same.
- R7: States 24 to 69 run in order twice, and state 70 follows the second pass.
- R8: States 70 to 108 run in order. After state 108 the machine is in state 0 with done high for exactly that one cycle. Done is low in every other cycle.
- R9: While the machine is outside state 0, a start pulse or a change of the scalar input has no effect on the state sequence or on key_bit.
- R10: Inversion states issue only multiplies and squares. The first inversion state reads operand select 2 on the first pass and operand select 4 on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when sampled high in state 0 |
| scalar | input | KEY_W | Scalar, captured when start is accepted |
| state_idx | output | 7 | Current state number |
| key_bit | output | 1 | Scalar bit under scan |
| op_code | output | 2 | Micro-operation: 0 none, 1 multiply, 2 add, 3 square |
| op_dst | output | 4 | Destination register select (15 = none) |
| op_src_a | output | 4 | First operand register select (15 = none) |
| op_src_b | output | 4 | Second operand register select (15 = none) |
| done | output | 1 | One-cycle completion pulse |

## Verification
When start is sampled high at a rising edge, the state index reads 1 right after that edge. From then on the state moves once per edge. The operation fields follow the state index with no added delay, since they are decoded from the current state and key bit. The key bit changes on the same edge that takes state 23 back to 7. Done rises on the edge after state 108, together with the return to state 0. The bench drives inputs and samples every output at the falling clock edge, stepping one rising edge at a time. Each sample is compared against a state walk built from the requirements.

// File: rtl/ecpm_seq_pkg.sv
package ecpm_seq_pkg;

   localparam int STATE_W = 7;
   localparam int RSEL_W  = 4;

   typedef logic [STATE_W-1:0] state_t;
   typedef logic [RSEL_W-1:0]  rsel_t;

   // fixed state map; the datapath schedule depends on these numbers
   localparam state_t ST_IDLE    = 7'd0;
   localparam state_t ST_CONV_LO = 7'd1;
   localparam state_t ST_CONV_HI = 7'd6;
   localparam state_t ST_LAD_LO  = 7'd7;
   localparam state_t ST_LAD_HI  = 7'd23;
   localparam state_t ST_INV_LO  = 7'd24;
   localparam state_t ST_INV_HI  = 7'd69;
   localparam state_t ST_TAIL_LO = 7'd70;
   localparam state_t ST_TAIL_HI = 7'd108;

   typedef enum logic [1:0] {
      OP_NOP = 2'd0,
      OP_MUL = 2'd1,
      OP_ADD = 2'd2,
      OP_SQR = 2'd3
   } op_e;

   // register file selects
   localparam rsel_t R_XP   = 4'd0;
   localparam rsel_t R_X1   = 4'd1;
   localparam rsel_t R_Z1   = 4'd2;
   localparam rsel_t R_X2   = 4'd3;
   localparam rsel_t R_Z2   = 4'd4;
   localparam rsel_t R_T1   = 4'd5;
   localparam rsel_t R_T2   = 4'd6;
   localparam rsel_t R_T3   = 4'd7;
   localparam rsel_t R_T4   = 4'd8;
   localparam rsel_t R_CB   = 4'd9;
   localparam rsel_t R_NONE = 4'd15;

   typedef struct packed {
      op_e   op;
      rsel_t dst;
      rsel_t src_a;
      rsel_t src_b;
   } uop_t;

   function automatic uop_t mk_uop(op_e o, rsel_t d, rsel_t a, rsel_t b);
      uop_t u;
      u.op    = o;
      u.dst   = d;
      u.src_a = a;
      u.src_b = b;
      return u;
   endfunction

   // exchange the two ladder points
   function automatic rsel_t ladder_swap(rsel_t r);
      case (r)
         R_X1:    return R_X2;
         R_X2:    return R_X1;
         R_Z1:    return R_Z2;
         R_Z2:    return R_Z1;
         default: return r;
      endcase
   endfunction

endpackage

// File: rtl/ecpm_seq_fsm.sv
module ecpm_seq_fsm
   import ecpm_seq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   ladder_last,
   output state_t state,
   output logic   load_key,
   output logic   step_key,
   output logic   inv_pass,
   output logic   done
);

   state_t nxt;

   always_comb begin
      nxt = state + 7'd1;
      if (state == ST_IDLE)
         nxt = start ? ST_CONV_LO : ST_IDLE;
      else if (state == ST_LAD_HI)
         nxt = ladder_last ? ST_INV_LO : ST_LAD_LO;
      else if (state == ST_INV_HI)
         nxt = inv_pass ? ST_TAIL_LO : ST_INV_LO;
      else if (state >= ST_TAIL_HI)
         nxt = ST_IDLE;
   end

   assign load_key = (state == ST_IDLE) && start;
   assign step_key = (state == ST_LAD_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         inv_pass <= 1'b0;
         done     <= 1'b0;
      end else begin
         state <= nxt;
         done  <= (state == ST_TAIL_HI);
         if (load_key)
            inv_pass <= 1'b0;
         else if (state == ST_INV_HI)
            inv_pass <= ~inv_pass;
      end
   end

endmodule

// File: rtl/ecpm_key_scan.sv
module ecpm_key_scan #(
   parameter int KEY_W = 163
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [KEY_W-1:0] scalar,
   output logic             key_bit,
   output logic             last
);

   localparam int SCAN_W = KEY_W - 1;
   localparam int IDX_W  = (SCAN_W > 1) ? $clog2(SCAN_W) : 1;
   localparam logic [IDX_W-1:0] IDX_START = IDX_W'(KEY_W - 2);

   logic [SCAN_W-1:0] scan_q;
   logic [IDX_W-1:0]  idx;
   logic              unused_msb;

   // the top bit is implied by the ladder start point
   assign unused_msb = scalar[KEY_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_q <= '0;
         idx    <= '0;
      end else if (load) begin
         scan_q <= scalar[SCAN_W-1:0];
         idx    <= IDX_START;
      end else if (step && (idx != '0)) begin
         idx <= idx - 1'b1;
      end
   end

   assign key_bit = scan_q[idx];
   assign last    = (idx == '0);

endmodule

// File: rtl/ecpm_uop_decode.sv
module ecpm_uop_decode
   import ecpm_seq_pkg::*;
(
   input  state_t state,
   input  logic   key_bit,
   input  logic   inv_pass,
   output uop_t   uop
);

   localparam int NFLD = 3;

   uop_t   base;
   state_t off;
   logic   in_ladder;
   logic   flip;
   rsel_t  fld_in  [NFLD];
   rsel_t  fld_out [NFLD];

   assign in_ladder = (state >= ST_LAD_LO) && (state <= ST_LAD_HI);
   assign flip      = in_ladder && !key_bit;

   always_comb begin
      base = mk_uop(OP_NOP, R_NONE, R_NONE, R_NONE);
      off  = '0;
      if ((state >= ST_CONV_LO) && (state <= ST_CONV_HI)) begin
         off = state - ST_CONV_LO;
         case (off)
            7'd0:    base = mk_uop(OP_SQR, R_Z2, R_XP, R_NONE);
            7'd2:    base = mk_uop(OP_SQR, R_X2, R_Z2, R_NONE);
            7'd4:    base = mk_uop(OP_ADD, R_X2, R_X2, R_CB);
            default: base = mk_uop(OP_NOP, R_NONE, R_NONE, R_NONE);
         endcase
      end else if (in_ladder) begin
         // schedule written for key bit 1; bubbles cover pipeline hazards
         off = state - ST_LAD_LO;
         case (off)
            7'd0:    base = mk_uop(OP_MUL, R_T1, R_X1, R_Z2);
            7'd1:    base = mk_uop(OP_MUL, R_T2, R_X2, R_Z1);
            7'd2:    base = mk_uop(OP_SQR, R_T3, R_X2, R_NONE);
            7'd3:    base = mk_uop(OP_SQR, R_T4, R_Z2, R_NONE);
            7'd4:    base = mk_uop(OP_ADD, R_Z1, R_T1, R_T2);
            7'd5:    base = mk_uop(OP_MUL, R_Z2, R_T3, R_T4);
            7'd6:    base = mk_uop(OP_MUL, R_T2, R_T1, R_T2);
            7'd7:    base = mk_uop(OP_SQR, R_X2, R_T3, R_NONE);
            7'd8:    base = mk_uop(OP_SQR, R_Z1, R_Z1, R_NONE);
            7'd9:    base = mk_uop(OP_SQR, R_T4, R_T4, R_NONE);
            7'd11:   base = mk_uop(OP_MUL, R_T1, R_XP, R_Z1);
            7'd12:   base = mk_uop(OP_MUL, R_T4, R_CB, R_T4);
            7'd14:   base = mk_uop(OP_ADD, R_X1, R_T1, R_T2);
            7'd16:   base = mk_uop(OP_ADD, R_X2, R_X2, R_T4);
            default: base = mk_uop(OP_NOP, R_NONE, R_NONE, R_NONE);
         endcase
      end else if ((state >= ST_INV_LO) && (state <= ST_INV_HI)) begin
         off = state - ST_INV_LO;
         if (off == '0)
            base = mk_uop(OP_SQR, R_T1, inv_pass ? R_Z2 : R_Z1, R_NONE);
         else if ((off % 7'd3) == 7'd2)
            base = mk_uop(OP_MUL, R_T1, R_T1, R_T3);
         else
            base = mk_uop(OP_SQR, R_T1, R_T1, R_NONE);
      end else if ((state >= ST_TAIL_LO) && (state <= ST_TAIL_HI)) begin
         off = state - ST_TAIL_LO;
         case (off % 7'd3)
            7'd0:    base = mk_uop(OP_MUL, R_T2, R_T2, R_T1);
            7'd1:    base = mk_uop(OP_ADD, R_T2, R_T2, R_XP);
            default: base = mk_uop(OP_NOP, R_NONE, R_NONE, R_NONE);
         endcase
      end
   end

   assign fld_in[0] = base.dst;
   assign fld_in[1] = base.src_a;
   assign fld_in[2] = base.src_b;

   for (genvar f = 0; f < NFLD; f++) begin : g_swap
      assign fld_out[f] = flip ? ladder_swap(fld_in[f]) : fld_in[f];
   end

   assign uop = mk_uop(base.op, fld_out[0], fld_out[1], fld_out[2]);

endmodule

// File: rtl/ecpm_sequencer.sv
module ecpm_sequencer #(
   parameter int KEY_W = 163
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [KEY_W-1:0] scalar,
   output logic [6:0]       state_idx,
   output logic             key_bit,
   output logic [1:0]       op_code,
   output logic [3:0]       op_dst,
   output logic [3:0]       op_src_a,
   output logic [3:0]       op_src_b,
   output logic             done
);
   import ecpm_seq_pkg::*;

   if (KEY_W < 3) begin : g_bad_key_w
      $error("ecpm_sequencer: KEY_W must be at least 3");
   end

   state_t state;
   logic   load_key;
   logic   step_key;
   logic   ladder_last;
   logic   inv_pass;
   uop_t   uop;

   ecpm_seq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .ladder_last (ladder_last),
      .state       (state),
      .load_key    (load_key),
      .step_key    (step_key),
      .inv_pass    (inv_pass),
      .done        (done)
   );

   ecpm_key_scan #(.KEY_W(KEY_W)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_key),
      .step    (step_key),
      .scalar  (scalar),
      .key_bit (key_bit),
      .last    (ladder_last)
   );

   ecpm_uop_decode u_dec (
      .state    (state),
      .key_bit  (key_bit),
      .inv_pass (inv_pass),
      .uop      (uop)
   );

   assign state_idx = state;
   assign op_code   = uop.op;
   assign op_dst    = uop.dst;
   assign op_src_a  = uop.src_a;
   assign op_src_b  = uop.src_b;

endmodule

// File: rtl/ecpm_seq_checker.sv
module ecpm_seq_checker
   import ecpm_seq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [6:0] state_idx,
   input logic       key_bit,
   input logic [1:0] op_code,
   input logic [3:0] op_src_a,
   input logic       done
);

   p_idle_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_idx == ST_IDLE) |-> (op_code == OP_NOP));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_idx == ST_IDLE) && !start) |=> (state_idx == ST_IDLE));

   p_start_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_idx == ST_IDLE) && start) |=> (state_idx == ST_CONV_LO));

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_idx >= ST_CONV_LO) && (state_idx < ST_LAD_HI))
      |=> (state_idx == $past(state_idx) + 7'd1));

   p_ladder_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_idx == ST_LAD_HI) |=> ((state_idx == ST_LAD_LO) || (state_idx == ST_INV_LO)));

   p_key_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_idx >= ST_LAD_LO) && (state_idx < ST_LAD_HI)) |=> $stable(key_bit));

   p_inv_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_idx == ST_INV_HI) |=> ((state_idx == ST_INV_LO) || (state_idx == ST_TAIL_LO)));

   p_inv_ops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_idx >= ST_INV_LO) && (state_idx <= ST_INV_HI))
      |-> ((op_code == OP_MUL) || (op_code == OP_SQR)));

   p_inv_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_idx == ST_INV_LO) |-> ((op_src_a == R_Z1) || (op_src_a == R_Z2)));

   p_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_idx == ST_TAIL_HI) |=> (done && (state_idx == ST_IDLE)));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind ecpm_sequencer ecpm_seq_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .state_idx (state_idx),
   .key_bit   (key_bit),
   .op_code   (op_code),
   .op_src_a  (op_src_a),
   .done      (done)
);

// File: tb/ecpm_sequencer_test.sv
`timescale 1ns/1ps
module ecpm_sequencer_test;

   localparam int KW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [KW-1:0] scalar = '0;
   logic [6:0]    state_idx;
   logic          key_bit;
   logic [1:0]    op_code;
   logic [3:0]    op_dst;
   logic [3:0]    op_src_a;
   logic [3:0]    op_src_b;
   logic          done;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   ecpm_sequencer #(.KEY_W(KW)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .scalar    (scalar),
      .state_idx (state_idx),
      .key_bit   (key_bit),
      .op_code   (op_code),
      .op_dst    (op_dst),
      .op_src_a  (op_src_a),
      .op_src_b  (op_src_b),
      .done      (done)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         checks = checks + 1;
         fails  = fails + 1;
         $display("FAIL watchdog: act=%0d exp=<100000", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic adv();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int swp(input int r);
      if (r == 1) return 3;
      if (r == 3) return 1;
      if (r == 2) return 4;
      if (r == 4) return 2;
      return r;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      chk("R1 state", int'(state_idx), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 op", int'(op_code), 0);
      rst_n = 1'b1;
      adv();
      chk("R1 state after release", int'(state_idx), 0);
   endtask

   task automatic t_idle();
      start = 1'b0;
      for (int i = 0; i < 6; i++) begin
         adv();
         chk("R2 idle hold", int'(state_idx), 0);
         chk("R2 no done", int'(done), 0);
      end
   endtask

   task automatic t_run(input logic [KW-1:0] sc, input bit perturb);
      int f1[17][4];
      int f0[17][4];
      bit have1 = 0;
      bit have0 = 0;
      int nmul, nadd, nsqr, nnop;
      scalar = sc;
      start  = 1'b1;
      for (int s = 1; s <= 6; s++) begin
         adv();
         if (s == 1) begin
            chk("R2 start accepted", int'(state_idx), 1);
            start = 1'b0;
         end else
            chk("R3 conversion order", int'(state_idx), s);
      end
      for (int p = KW - 2; p >= 0; p--) begin
         nmul = 0; nadd = 0; nsqr = 0; nnop = 0;
         for (int s = 7; s <= 23; s++) begin
            adv();
            start = 1'b0;
            chk("R4 ladder state", int'(state_idx), s);
            chk("R4 key bit", int'(key_bit), int'(sc[p]));
            chk("R8 done low", int'(done), 0);
            case (op_code)
               2'd1: nmul++;
               2'd2: nadd++;
               2'd3: nsqr++;
               default: nnop++;
            endcase
            if (sc[p] && !have1) begin
               f1[s-7][0] = op_code; f1[s-7][1] = op_dst;
               f1[s-7][2] = op_src_a; f1[s-7][3] = op_src_b;
            end
            if (!sc[p] && !have0) begin
               f0[s-7][0] = op_code; f0[s-7][1] = op_dst;
               f0[s-7][2] = op_src_a; f0[s-7][3] = op_src_b;
            end
            // R9: busy start pulse and scalar change
            if (perturb && p == KW - 3 && s == 10) begin
               start  = 1'b1;
               scalar = ~sc;
            end
         end
         if (sc[p]) have1 = 1; else have0 = 1;
         chk("R5 multiplies", nmul, 6);
         chk("R5 adds", nadd, 3);
         chk("R5 squares", nsqr, 5);
         chk("R5 bubbles", nnop, 3);
      end
      for (int q = 0; q < 2; q++) begin
         for (int s = 24; s <= 69; s++) begin
            adv();
            chk("R7 inversion state", int'(state_idx), s);
            chk("R10 inversion op", int'(op_code == 2'd1 || op_code == 2'd3), 1);
            if (s == 24)
               chk("R10 inversion source", int'(op_src_a), (q == 0) ? 2 : 4);
         end
      end
      for (int s = 70; s <= 108; s++) begin
         adv();
         chk("R8 tail state", int'(state_idx), s);
         chk("R8 done low", int'(done), 0);
      end
      adv();
      chk("R8 return idle", int'(state_idx), 0);
      chk("R8 done pulse", int'(done), 1);
      adv();
      chk("R8 done one cycle", int'(done), 0);
      chk("R9 stays idle", int'(state_idx), 0);
      if (have1 && have0) begin
         for (int k = 0; k < 17; k++) begin
            chk("R6 op equal", f0[k][0], f1[k][0]);
            for (int f = 1; f < 4; f++)
               chk("R6 swapped select", f0[k][f], swp(f1[k][f]));
         end
      end
      scalar = '0;
   endtask

   initial begin
      t_reset();
      t_idle();
      t_run(8'b1010_0110, 1'b1);
      t_idle();
      t_run(8'b0111_1001, 1'b0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule